// File: doc/BRIEF.md
# Bandwidth Slot Schedule Builder

This block computes the contents of a 64-entry time-slot table for a shared memory arbiter. Each entry names the client that owns that slot. A build starts from three inputs sampled on a start pulse: the slot count each client has requested, a per-client active flag, and a count of slots still free for idle clients.

The build runs in two passes. The placement pass walks the clients in ascending index order and spreads each client's slots at an even stride. When a position is already taken, the cursor moves on by one. An active client that requested nothing is given one slot, as long as the free count allows it. The gap-fill pass then hands every still-empty slot to active clients in round-robin order. As each slot is settled it is streamed out on a write port with its index, and a one-cycle done pulse ends the build.

A separate combinational path performs admission control. It turns a requested bandwidth, taken against the region's capacity, into a slot count, and reports whether that count still fits beside the slots already assigned.

Top module: `slot_sched_builder`

## Requirements
- R1: After reset, busy, wr_valid and done are all 0.
- R2: The placement pass handles clients in ascending index order. A client with a nonzero request N has stride 64/N (integer division). Its cursor starts at slot 0. When the slot under the cursor is taken, the cursor moves by 1. Otherwise the client is written into that slot and the cursor moves by the stride. The client's placement stops once the cursor exceeds 63.
- R3: A client that is active and has a zero request is placed with stride 64, so it gets exactly one slot, the first free one. This happens only while the free count sampled at start is nonzero, and each such grant lowers that count by one.
- R4: A client that is inactive and has a zero request gets no slot in the placement pass, whatever the free count.
- R5: In the gap-fill pass, a round-robin cursor starts at client 0. Each empty slot, taken in slot order, goes to the first active client at or after the cursor, wrapping after client 13. After each fill the cursor moves to that client plus one, modulo 14. Slots that are already taken do not move the cursor.
- R6: If no client is active, each empty slot receives the cursor's current value, and the cursor still advances by one.
- R7: A build writes the slots in the order 0 to 63, one per cycle, with wr_valid high and wr_data holding the client index. done is high for exactly one cycle, in the cycle after slot 63 is written.
- R8: A start pulse that arrives while busy is high has no effect on the build in progress.
- R9: The admission slot count adm_slots is 64 / (adm_capacity / adm_bw), both divisions integer. It is 0 when adm_bw is 0, and also 0 when adm_capacity / adm_bw is 0.
- R10: adm_ok is 1 exactly when adm_capacity / adm_bw is nonzero (or adm_bw is 0) and adm_assigned + adm_slots is at most 64.
- R11: Requests, active flags and the free count are sampled on the start pulse. Changes to them during a build do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a build |
| req_slots | input | NUM_CLIENTS*RW | Requested slot count for each client; client i occupies bits [i*RW +: RW] |
| active | input | NUM_CLIENTS | Active flag for each client |
| free_slots | input | RW | Number of free slots that may be handed to idle clients |
| busy | output | 1 | High while a build is running |
| wr_valid | output | 1 | A table entry is being written |
| wr_idx | output | SW | Slot index of the entry being written |
| wr_data | output | CW | Client index that owns the slot |
| done | output | 1 | One-cycle pulse marking the end of a build |
| adm_capacity | input | BW_W | Bandwidth capacity of the region |
| adm_bw | input | BW_W | Requested bandwidth |
| adm_assigned | input | RW | Total slots already assigned in the region |
| adm_slots | output | RW | Slot count derived from the request |
| adm_ok | output | 1 | The request fits |

## Verification
The bench builds the block with its default parameters: 64 slots, 14 clients and a 32-bit bandwidth field. At that size, a bench-side model of both passes covers the real table. Directed builds exercise stride collisions, the free-count limit for idle clients, inactive clients and the case where no client is active. About forty pseudo-random builds, each compared entry by entry against the model, mix these cases freely. The admission path is swept over every bandwidth from 0 to 130 against a capacity of 100, at four levels of already-assigned slots. That sweep reaches the zero-bandwidth case, the zero-quotient case and the exact-fit boundary at 64 slots.

// File: rtl/slot_sched_builder.sv
module slot_sched_builder #(
  parameter int NUM_SLOTS   = 64,
  parameter int NUM_CLIENTS = 14,
  parameter int BW_W        = 32,
  localparam int SW  = $clog2(NUM_SLOTS),
  localparam int RW  = SW + 1,
  localparam int CW  = $clog2(NUM_CLIENTS),
  localparam int CLW = $clog2(NUM_CLIENTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NUM_CLIENTS*RW-1:0] req_slots,
  input  logic [NUM_CLIENTS-1:0]    active,
  input  logic [RW-1:0]             free_slots,
  output logic                      busy,
  output logic                      wr_valid,
  output logic [SW-1:0]             wr_idx,
  output logic [CW-1:0]             wr_data,
  output logic                      done,
  input  logic [BW_W-1:0]           adm_capacity,
  input  logic [BW_W-1:0]           adm_bw,
  input  logic [RW-1:0]             adm_assigned,
  output logic [RW-1:0]             adm_slots,
  output logic                      adm_ok
);

  typedef enum logic [1:0] {S_IDLE, S_PLACE, S_FILL, S_DONE} st_t;

  st_t                  st;
  logic [CLW-1:0]       cl;
  logic                 inpl;
  logic [RW:0]          pos;
  logic [RW-1:0]        stride;
  logic [RW-1:0]        free_q;
  logic [RW-1:0]        req_q [NUM_CLIENTS];
  logic [NUM_CLIENTS-1:0] act_q;
  logic [NUM_SLOTS-1:0] occ;
  logic [CW-1:0]        tbl [NUM_SLOTS];
  logic [SW-1:0]        slot;
  logic [CW-1:0]        rr;

  logic [RW-1:0] cur_req;
  logic          cur_act;
  logic          cl_end;
  logic          in_range;
  logic          take_idle;
  logic [CW-1:0] pick;
  logic [CW-1:0] pick_next;

  assign cl_end    = cl == CLW'(NUM_CLIENTS);
  assign cur_req   = cl_end ? '0 : req_q[cl[CW-1:0]];
  assign cur_act   = cl_end ? 1'b0 : act_q[cl[CW-1:0]];
  assign take_idle = cur_req == '0 && cur_act && free_q != '0;
  assign in_range  = pos < (RW+1)'(NUM_SLOTS);

  always_comb begin
    pick = rr;
    for (int k = NUM_CLIENTS - 1; k >= 0; k--) begin
      if (act_q[(int'(rr) + k) % NUM_CLIENTS])
        pick = CW'((int'(rr) + k) % NUM_CLIENTS);
    end
  end
  assign pick_next = (pick == CW'(NUM_CLIENTS - 1)) ? '0 : pick + 1'b1;

  assign busy     = st != S_IDLE;
  assign wr_valid = st == S_FILL;
  assign wr_idx   = slot;
  assign wr_data  = occ[slot] ? tbl[slot] : pick;
  assign done     = st == S_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cl     <= '0;
      inpl   <= 1'b0;
      pos    <= '0;
      stride <= '0;
      free_q <= '0;
      act_q  <= '0;
      occ    <= '0;
      slot   <= '0;
      rr     <= '0;
      for (int i = 0; i < NUM_CLIENTS; i++) req_q[i] <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) tbl[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_PLACE;
          cl     <= '0;
          inpl   <= 1'b0;
          occ    <= '0;
          free_q <= free_slots;
          act_q  <= active;
          for (int i = 0; i < NUM_CLIENTS; i++) req_q[i] <= req_slots[i*RW +: RW];
        end
        S_PLACE: begin
          if (!inpl) begin
            if (cl_end) begin
              st   <= S_FILL;
              slot <= '0;
              rr   <= '0;
            end else if (cur_req != '0) begin
              stride <= RW'(NUM_SLOTS) / cur_req;
              pos    <= '0;
              inpl   <= 1'b1;
            end else if (take_idle) begin
              stride <= RW'(NUM_SLOTS);
              free_q <= free_q - 1'b1;
              pos    <= '0;
              inpl   <= 1'b1;
            end else begin
              cl <= cl + 1'b1;
            end
          end else if (!in_range) begin
            inpl <= 1'b0;
            cl   <= cl + 1'b1;
          end else if (occ[pos[SW-1:0]]) begin
            pos <= pos + 1'b1;
          end else begin
            occ[pos[SW-1:0]] <= 1'b1;
            tbl[pos[SW-1:0]] <= cl[CW-1:0];
            pos <= pos + {1'b0, stride};
          end
        end
        S_FILL: begin
          if (!occ[slot]) rr <= pick_next;
          if (slot == SW'(NUM_SLOTS - 1)) st <= S_DONE;
          else slot <= slot + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [BW_W-1:0] adm_q;
  logic [RW:0]     adm_sum;
  assign adm_q     = (adm_bw == '0) ? '0 : adm_capacity / adm_bw;
  assign adm_slots = (adm_q == '0) ? '0 : RW'(BW_W'(NUM_SLOTS) / adm_q);
  assign adm_sum   = {1'b0, adm_assigned} + {1'b0, adm_slots};
  assign adm_ok    = (adm_bw == '0 || adm_q != '0) && adm_sum <= (RW+1)'(NUM_SLOTS);

  p_data_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> int'(wr_data) < NUM_CLIENTS);
  p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_idx != SW'(NUM_SLOTS - 1) |=> wr_valid && wr_idx == $past(wr_idx) + 1'b1);
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_idx == SW'(NUM_SLOTS - 1) |=> done);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  p_place_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PLACE && inpl && !in_range |=> !inpl && cl == $past(cl) + 1'b1);
  p_free_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PLACE && $past(st) == S_PLACE && free_q != $past(free_q) |-> free_q == $past(free_q) - 1'b1);
  p_adm_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adm_bw == '0 |-> adm_slots == '0);
  p_adm_fit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adm_ok |-> int'(adm_assigned) + int'(adm_slots) <= NUM_SLOTS);

endmodule

// File: tb/slot_sched_builder_tb.sv
module slot_sched_builder_tb;
  localparam int NS = 64, NC = 14, RW = 7, SW = 6, CW = 4, BW = 32;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NC*RW-1:0] req_slots = '0;
  logic [NC-1:0] active = '0;
  logic [RW-1:0] free_slots = '0;
  logic busy, wr_valid, done, adm_ok;
  logic [SW-1:0] wr_idx;
  logic [CW-1:0] wr_data;
  logic [BW-1:0] adm_capacity = '0, adm_bw = '0;
  logic [RW-1:0] adm_assigned = '0, adm_slots;

  always #10 clk = ~clk;

  slot_sched_builder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_slots(req_slots), .active(active),
    .free_slots(free_slots), .busy(busy), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_data(wr_data), .done(done), .adm_capacity(adm_capacity), .adm_bw(adm_bw),
    .adm_assigned(adm_assigned), .adm_slots(adm_slots), .adm_ok(adm_ok));

  int n_chk = 0, n_fail = 0;
  int m_req[NC];
  bit m_act[NC];
  int m_free;
  int exp_t[NS];
  int got[NS];
  int n_wr, n_done, order_bad, cyc, last_cyc, done_cyc, exp_idx;
  logic [31:0] lfsr = 32'h1ACE5EED;

  task automatic check(input string tag, input bit ok, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (wr_valid) begin
      if (int'(wr_idx) != exp_idx) order_bad++;
      got[wr_idx] = int'(wr_data);
      exp_idx++;
      n_wr++;
      last_cyc = cyc;
    end
    if (done) begin
      n_done++;
      done_cyc = cyc;
    end
  end

  task automatic model();
    int fr, pos, st, rr, first;
    fr = m_free;
    for (int s = 0; s < NS; s++) exp_t[s] = -1;
    for (int c = 0; c < NC; c++) begin
      if (m_req[c] != 0) st = NS / m_req[c];
      else if (m_act[c] && fr > 0) begin fr--; st = NS; end
      else continue;
      pos = 0;
      while (pos < NS) begin
        if (exp_t[pos] >= 0) pos++;
        else begin exp_t[pos] = c; pos += st; end
      end
    end
    rr = 0;
    for (int s = 0; s < NS; s++) begin
      if (exp_t[s] < 0) begin
        first = rr;
        while (!m_act[rr]) begin
          rr = (rr + 1) % NC;
          if (rr == first) break;
        end
        exp_t[s] = rr;
        rr = (rr + 1) % NC;
      end
    end
  endtask

  task automatic drive_inputs();
    for (int c = 0; c < NC; c++) begin
      req_slots[c*RW +: RW] = RW'(m_req[c]);
      active[c] = m_act[c];
    end
    free_slots = RW'(m_free);
  endtask

  task automatic build(input string tag, input bit disturb);
    int mism, first_bad, to;
    model();
    drive_inputs();
    n_wr = 0; n_done = 0; order_bad = 0; exp_idx = 0; done_cyc = 0; last_cyc = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (disturb) begin
      repeat (5) @(negedge clk);
      req_slots = ~req_slots; active = ~active; free_slots = '1;
      start = 1;
      @(negedge clk); start = 0;
      check("R8 busy held", busy === 1'b1, busy, 1);
    end
    to = 0;
    while (n_done == 0 && to < 5000) begin @(negedge clk); to++; end
    repeat (3) @(negedge clk);
    mism = 0; first_bad = -1;
    for (int s = 0; s < NS; s++)
      if (got[s] != exp_t[s]) begin mism++; if (first_bad < 0) first_bad = s; end
    check(tag, mism == 0, first_bad < 0 ? 0 : got[first_bad], first_bad < 0 ? 0 : exp_t[first_bad]);
    check("R7 write count/order", n_wr == NS && order_bad == 0, n_wr, NS);
    check("R7 done single, after last", n_done == 1 && done_cyc == last_cyc + 1, done_cyc, last_cyc + 1);
  endtask

  task automatic clear_cfg();
    for (int c = 0; c < NC; c++) begin m_req[c] = 0; m_act[c] = 0; end
    m_free = 0;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #(20 * 200000);
    check("watchdog", 0, 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy === 1'b0, busy, 0);
    check("R1 wr_valid", wr_valid === 1'b0, wr_valid, 0);
    check("R1 done", done === 1'b0, done, 0);
    rst_n = 1;
    @(negedge clk);

    clear_cfg();
    build("R6 no active clients", 0);

    clear_cfg();
    m_req[0] = 8; m_req[1] = 4; m_req[2] = 2; m_act[0] = 1; m_act[1] = 1; m_act[2] = 1;
    build("R2 strides", 0);

    clear_cfg();
    m_req[0] = 3; m_req[1] = 3; m_req[5] = 5; m_act[0] = 1; m_act[1] = 1; m_act[5] = 1;
    build("R2 collisions", 0);

    clear_cfg();
    for (int c = 3; c < 8; c++) m_act[c] = 1;
    m_req[0] = 32; m_act[0] = 1; m_free = 3;
    build("R3 idle grants limited by free count", 0);

    clear_cfg();
    m_act[4] = 1; m_act[9] = 1; m_act[13] = 1; m_free = 20;
    build("R4 inactive get nothing", 0);

    clear_cfg();
    m_act[12] = 1; m_act[1] = 1; m_req[6] = 16;
    build("R5 round robin wrap", 0);

    clear_cfg();
    m_req[2] = 4; m_act[2] = 1; m_act[7] = 1; m_act[11] = 1; m_free = 2;
    build("R11 R8 start and inputs during build", 1);

    for (int t = 0; t < 40; t++) begin
      int tot;
      clear_cfg();
      tot = 0;
      for (int c = 0; c < NC; c++) begin
        lfsr = nxt(lfsr);
        m_act[c] = lfsr[3];
        if (lfsr[7:5] == 3'd0 && tot < 48) begin
          m_req[c] = 1 + int'(lfsr[12:9]);
          tot += m_req[c];
          m_act[c] = 1;
        end
      end
      lfsr = nxt(lfsr);
      m_free = int'(lfsr[4:0]) % 8;
      build("R5 random mix", 0);
    end

    adm_capacity = 100;
    for (int a = 0; a < 4; a++) begin
      int asg, q, es, eo;
      asg = (a == 0) ? 0 : (a == 1) ? 30 : (a == 2) ? 60 : 64;
      for (int bw = 0; bw <= 130; bw++) begin
        adm_assigned = RW'(asg);
        adm_bw = bw;
        #1;
        if (bw == 0) begin es = 0; eo = (asg <= 64); end
        else begin
          q = 100 / bw;
          if (q == 0) begin es = 0; eo = 0; end
          else begin es = 64 / q; eo = (asg + es <= 64); end
        end
        check("R9 adm slots", int'(adm_slots) == es, adm_slots, es);
        check("R10 adm ok", adm_ok == eo[0], adm_ok, eo);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule